// File: doc/BRIEF.md
# Removable ATA Card Host Bus Decoder

This block is the host-facing bus front end of a removable ATA storage card. Each cycle it looks at the host address, the two active-low card enables, the register-select line and the four host strobes (memory read and write, I/O read and write). From these it works out which space the cycle targets: attribute memory, common memory, an I/O register, a task-file register or a control register. It then presents the cycle to an internal register port with a byte-lane enable pair, and it steers bytes between the 16-bit host data bus and that port.

The card runs in one of three modes: memory, I/O or True IDE. The mode is captured while reset is held and stays fixed until the next reset. Reads go straight through the decoder in the same cycle. A write is handed to the internal port as a single-cycle pulse once the host write strobe returns high, so the value on the bus at the trailing edge is the one that gets stored. The block also drives the input-acknowledge and 16-bit-port outputs that the host socket expects.

Top module: `ata_host_decoder`

## Requirements
- R1: While `rst` is high, the mode is captured each cycle: `host_oe_n` low selects IDE (`mode_o`=2); otherwise `cfg_io` high selects I/O (1); otherwise memory (0). After reset release `mode_o` holds, whatever `host_oe_n` and `cfg_io` do.
- R2: In memory and I/O modes, both enables low select a word (`be`=11). `host_ce1_n` low alone selects the even byte (`be`=01) when A0=0 or the odd byte (`be`=10) when A0=1, both on D[7:0]. `host_ce2_n` low alone selects the odd byte (`be`=10) on D[15:8]. The port address is A[10:1] with bit 0 cleared.
- R3: In memory mode the memory strobes reach common memory (space 2) when `host_reg_n` is high and attribute memory (space 1) when it is low. The I/O strobes are ignored.
- R4: In I/O mode the I/O strobes with `host_reg_n` low reach I/O space (3), and the memory strobes with `host_reg_n` low reach attribute memory (1). Any strobe with `host_reg_n` high is ignored.
- R5: In IDE mode only the I/O strobes count. `host_ce1_n` low alone selects the task file (4) and `host_ce2_n` low alone selects the control registers (5). The port address is A[2:0]. Task register 0 is a word (`be`=11); every other register is a byte on D[7:0] (`be`=01). Both selects low, or `host_reg_n`, `host_oe_n` and `host_we_n`, select or change nothing.
- R6: With both card enables high, no read, no write pulse and no bus drive is produced.
- R7: `host_doe` and `rd_en` are high exactly while a read strobe decodes to a space. `host_dout[7:0]` carries `rd_data[15:8]` for an odd byte on D[7:0] and `rd_data[7:0]` otherwise. `host_dout[15:8]` carries `rd_data[15:8]`. `host_dout` is 0 when not driving.
- R8: A decoded write yields `wr_en` for exactly one cycle, in the cycle after the write strobe goes high. It carries the space, address and lanes of the last cycle the strobe was low. It never fires while the strobe is low. `wr_data[7:0]`=D[7:0]; `wr_data[15:8]`=D[7:0] for an odd byte on D[7:0] and D[15:8] otherwise.
- R9: `host_inpack_n` is low only in I/O mode during an I/O read that decodes to I/O space.
- R10: `host_iois16_n` is low in I/O mode when an enable is low, `host_reg_n` is low and A[2:0]=0. It is low in IDE mode when `host_ce1_n` alone is low and A[2:0]=0. It is held low in memory mode.
- R11: After reset with an idle bus, `wr_en`, `rd_en` and `host_doe` are 0 and `host_inpack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode capture window |
| cfg_io | input | 1 | Requests I/O mode at reset |
| host_addr | input | 11 | Host address |
| host_ce1_n | input | 1 | Card enable 1 / IDE task-file select |
| host_ce2_n | input | 1 | Card enable 2 / IDE control select |
| host_reg_n | input | 1 | Register-space select, low for attribute and I/O |
| host_oe_n | input | 1 | Memory read strobe; low at reset selects IDE |
| host_we_n | input | 1 | Memory write strobe |
| host_iord_n | input | 1 | I/O read strobe |
| host_iowr_n | input | 1 | I/O write strobe |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Host read data |
| host_doe | output | 1 | Host data bus drive enable |
| host_inpack_n | output | 1 | Input acknowledge, active low |
| host_iois16_n | output | 1 | 16-bit port indication, active low |
| mode_o | output | 2 | Latched mode: 0 memory, 1 I/O, 2 IDE |
| rd_en | output | 1 | Read access active |
| rd_space | output | 3 | Read target space |
| rd_addr | output | 11 | Read port address |
| rd_be | output | 2 | Read byte enables (bit 0 even, bit 1 odd) |
| rd_data | input | 16 | Internal read data {odd, even} |
| wr_en | output | 1 | Write pulse |
| wr_space | output | 3 | Write target space |
| wr_addr | output | 11 | Write port address |
| wr_be | output | 2 | Write byte enables |
| wr_data | output | 16 | Write data {odd, even} |

## Verification
Reads are driven from a table that walks every enable and A0 combination in memory and I/O modes. This shows even, odd-on-low-lane, odd-on-high-lane and word lanes, each marked by a different `host_dout` pattern from a fixed internal word. The table also flips `host_reg_n` and mixes memory and I/O strobes in each mode, which separates common, attribute and I/O space and the ignored cases. In IDE mode the two selects, the word data register against byte registers, both selects low and the unused memory strobe are applied. Directed write cycles change the data while the strobe is still low, to show trailing-edge capture, and they cover lane steering, mode hold and an idle write.

// File: rtl/ata_hbd_pkg.sv
package ata_hbd_pkg;
    localparam int HA_W   = 11;
    localparam int HD_W   = 16;
    localparam int LANES  = HD_W / 8;
    localparam int TF_W   = 3;

    typedef enum logic [1:0] {
        MODE_MEM = 2'd0,
        MODE_IO  = 2'd1,
        MODE_IDE = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        SP_NONE   = 3'd0,
        SP_ATTR   = 3'd1,
        SP_COMMON = 3'd2,
        SP_IO     = 3'd3,
        SP_TASK   = 3'd4,
        SP_CTRL   = 3'd5
    } space_e;

    typedef struct packed {
        space_e            space;
        logic [HA_W-1:0]   addr;
        logic [LANES-1:0]  be;
        logic              odd_low;
    } dec_t;

    localparam dec_t DEC_IDLE = '{space: SP_NONE, addr: '0, be: '0, odd_low: 1'b0};

    function automatic mode_e pick_mode(input logic oe_n, input logic io_cfg);
        if (!oe_n)      return MODE_IDE;
        else if (io_cfg) return MODE_IO;
        else            return MODE_MEM;
    endfunction

    // bit 0 = even byte, bit 1 = odd byte
    function automatic logic [LANES-1:0] lane_enables(input logic ce1_n, input logic ce2_n,
                                                      input logic a0);
        logic [LANES-1:0] be;
        be[1] = !ce2_n || (!ce1_n && a0);
        be[0] = !ce1_n && (!a0 || !ce2_n);
        return be;
    endfunction

    function automatic logic [HD_W-1:0] steer_to_port(input logic [HD_W-1:0] bus,
                                                      input logic odd_low);
        return {(odd_low ? bus[7:0] : bus[15:8]), bus[7:0]};
    endfunction

    function automatic logic [HD_W-1:0] steer_to_host(input logic [HD_W-1:0] word,
                                                      input logic odd_low);
        return {word[15:8], (odd_low ? word[15:8] : word[7:0])};
    endfunction
endpackage

// File: rtl/ata_mode_latch.sv
module ata_mode_latch
    import ata_hbd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  oe_n,
    input  logic  io_cfg,
    output mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst) mode <= pick_mode(oe_n, io_cfg);
    end
endmodule

// File: rtl/ata_space_decode.sv
module ata_space_decode
    import ata_hbd_pkg::*;
(
    input  mode_e            mode,
    input  logic [HA_W-1:0]  addr,
    input  logic             ce1_n,
    input  logic             ce2_n,
    input  logic             reg_n,
    input  logic             mem_stb_n,
    input  logic             io_stb_n,
    output dec_t             dec
);
    logic   any_ce, mem_only, io_only, tf_word;
    space_e sp;

    assign any_ce   = !ce1_n || !ce2_n;
    assign mem_only = !mem_stb_n && io_stb_n;
    assign io_only  = !io_stb_n && mem_stb_n;
    assign tf_word  = (addr[TF_W-1:0] == '0);

    always_comb begin
        sp = SP_NONE;
        unique case (mode)
            MODE_MEM: if (mem_only && any_ce) sp = reg_n ? SP_COMMON : SP_ATTR;
            MODE_IO: begin
                if (io_only && any_ce && !reg_n)       sp = SP_IO;
                else if (mem_only && any_ce && !reg_n) sp = SP_ATTR;
            end
            MODE_IDE: if (!io_stb_n && (ce1_n != ce2_n)) sp = !ce1_n ? SP_TASK : SP_CTRL;
            default: sp = SP_NONE;
        endcase
    end

    always_comb begin
        dec = DEC_IDLE;
        if (sp == SP_TASK || sp == SP_CTRL) begin
            dec.space = sp;
            dec.addr  = {{(HA_W-TF_W){1'b0}}, addr[TF_W-1:0]};
            dec.be    = (sp == SP_TASK && tf_word) ? 2'b11 : 2'b01;
        end else if (sp != SP_NONE) begin
            dec.space   = sp;
            dec.addr    = {addr[HA_W-1:1], 1'b0};
            dec.be      = lane_enables(ce1_n, ce2_n, addr[0]);
            dec.odd_low = !ce1_n && ce2_n && addr[0];
        end
    end
endmodule

// File: rtl/ata_write_capture.sv
module ata_write_capture
    import ata_hbd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  dec_t            wdec,
    input  logic [HD_W-1:0] din,
    input  logic            stb_idle,
    output logic            wr_en,
    output dec_t            wr_dec,
    output logic [HD_W-1:0] wr_data
);
    dec_t            held;
    logic            held_act;
    logic [HD_W-1:0] held_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_act  <= 1'b0;
            held      <= DEC_IDLE;
            held_data <= '0;
            wr_en     <= 1'b0;
            wr_dec    <= DEC_IDLE;
            wr_data   <= '0;
        end else begin
            held_act  <= (wdec.space != SP_NONE);
            held      <= wdec;
            held_data <= steer_to_port(din, wdec.odd_low);
            wr_en     <= held_act && stb_idle;
            if (held_act && stb_idle) begin
                wr_dec  <= held;
                wr_data <= held_data;
            end
        end
    end
endmodule

// File: rtl/ata_host_decoder.sv
module ata_host_decoder
    import ata_hbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_io,
    input  logic [HA_W-1:0]  host_addr,
    input  logic             host_ce1_n,
    input  logic             host_ce2_n,
    input  logic             host_reg_n,
    input  logic             host_oe_n,
    input  logic             host_we_n,
    input  logic             host_iord_n,
    input  logic             host_iowr_n,
    input  logic [HD_W-1:0]  host_din,
    output logic [HD_W-1:0]  host_dout,
    output logic             host_doe,
    output logic             host_inpack_n,
    output logic             host_iois16_n,
    output logic [1:0]       mode_o,
    output logic             rd_en,
    output logic [2:0]       rd_space,
    output logic [HA_W-1:0]  rd_addr,
    output logic [LANES-1:0] rd_be,
    input  logic [HD_W-1:0]  rd_data,
    output logic             wr_en,
    output logic [2:0]       wr_space,
    output logic [HA_W-1:0]  wr_addr,
    output logic [LANES-1:0] wr_be,
    output logic [HD_W-1:0]  wr_data
);
    mode_e mode;
    dec_t  dec [2];
    dec_t  wr_dec;
    logic  mem_stb [2];
    logic  io_stb  [2];
    logic  wr_idle, rhit;

    assign mem_stb[0] = host_oe_n;
    assign mem_stb[1] = host_we_n;
    assign io_stb[0]  = host_iord_n;
    assign io_stb[1]  = host_iowr_n;

    ata_mode_latch u_mode (
        .clk(clk), .rst(rst), .oe_n(host_oe_n), .io_cfg(cfg_io), .mode(mode)
    );

    // index 0 decodes reads, index 1 decodes writes
    for (genvar g = 0; g < 2; g++) begin : g_dir
        ata_space_decode u_dec (
            .mode(mode), .addr(host_addr), .ce1_n(host_ce1_n), .ce2_n(host_ce2_n),
            .reg_n(host_reg_n), .mem_stb_n(mem_stb[g]), .io_stb_n(io_stb[g]),
            .dec(dec[g])
        );
    end

    assign wr_idle = (mode == MODE_IDE) ? host_iowr_n : (host_we_n && host_iowr_n);

    ata_write_capture u_wcap (
        .clk(clk), .rst(rst), .wdec(dec[1]), .din(host_din), .stb_idle(wr_idle),
        .wr_en(wr_en), .wr_dec(wr_dec), .wr_data(wr_data)
    );

    assign rhit      = (dec[0].space != SP_NONE);
    assign rd_en     = rhit;
    assign rd_space  = dec[0].space;
    assign rd_addr   = dec[0].addr;
    assign rd_be     = dec[0].be;
    assign host_doe  = rhit;
    assign host_dout = rhit ? steer_to_host(rd_data, dec[0].odd_low) : '0;

    assign wr_space  = wr_dec.space;
    assign wr_addr   = wr_dec.addr;
    assign wr_be     = wr_dec.be;
    assign mode_o    = mode;

    assign host_inpack_n = !(mode == MODE_IO && dec[0].space == SP_IO);

    always_comb begin
        unique case (mode)
            MODE_IO:  host_iois16_n = !((!host_ce1_n || !host_ce2_n) && !host_reg_n
                                        && host_addr[TF_W-1:0] == '0);
            MODE_IDE: host_iois16_n = !(!host_ce1_n && host_ce2_n
                                        && host_addr[TF_W-1:0] == '0);
            default:  host_iois16_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/ata_host_decoder_chk.sv
module ata_host_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_o,
    input logic       host_ce1_n,
    input logic       host_ce2_n,
    input logic       host_oe_n,
    input logic       host_we_n,
    input logic       host_iord_n,
    input logic       host_iowr_n,
    input logic       host_doe,
    input logic       host_inpack_n,
    input logic       rd_en,
    input logic [1:0] rd_be,
    input logic       wr_en
);
    a_r1_mode_held: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_o));
    a_r2_lanes_set: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_be != 2'b00));
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (host_ce1_n && host_ce2_n) |-> (!rd_en && !host_doe));
    a_r7_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
        host_doe |-> (!host_oe_n || !host_iord_n));
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    a_r8_after_release: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(mode_o == 2'd2 ? host_iowr_n : (host_we_n && host_iowr_n)));
    a_r9_inpack_io_read: assert property (@(posedge clk) disable iff (rst)
        !host_inpack_n |-> (mode_o == 2'd1 && !host_iord_n));
endmodule

bind ata_host_decoder ata_host_decoder_chk u_chk (
    .clk(clk), .rst(rst), .mode_o(mode_o),
    .host_ce1_n(host_ce1_n), .host_ce2_n(host_ce2_n),
    .host_oe_n(host_oe_n), .host_we_n(host_we_n),
    .host_iord_n(host_iord_n), .host_iowr_n(host_iowr_n),
    .host_doe(host_doe), .host_inpack_n(host_inpack_n),
    .rd_en(rd_en), .rd_be(rd_be), .wr_en(wr_en)
);

// File: tb/test_ata_host_decoder.sv
module test_ata_host_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_io = 1'b0;
    logic [10:0] host_addr = '0;
    logic        host_ce1_n = 1'b1, host_ce2_n = 1'b1, host_reg_n = 1'b1;
    logic        host_oe_n = 1'b1, host_we_n = 1'b1, host_iord_n = 1'b1, host_iowr_n = 1'b1;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        host_doe, host_inpack_n, host_iois16_n;
    logic [1:0]  mode_o;
    logic        rd_en;
    logic [2:0]  rd_space;
    logic [10:0] rd_addr;
    logic [1:0]  rd_be;
    logic [15:0] rd_data = 16'hC3A5;
    logic        wr_en;
    logic [2:0]  wr_space;
    logic [10:0] wr_addr;
    logic [1:0]  wr_be;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ata_host_decoder i_ata_host_decoder (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] md);
        @(negedge clk);
        rst = 1'b1;
        host_oe_n = (md != 2'd2);
        cfg_io = (md == 2'd1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        host_oe_n = 1'b1;
        #1;
        chk("R1 mode", {14'd0, mode_o}, {14'd0, md});
    endtask

    // mode, ce1_n, ce2_n, reg_n, addr, use_io, space, be, port addr, doe, inpack_n, iois16_n, dout
    typedef struct packed {
        logic [1:0] md; logic ce1n; logic ce2n; logic regn; logic [10:0] a; logic use_io;
        logic [2:0] sp; logic [1:0] be; logic [10:0] ea; logic doe; logic inp; logic i16;
        logic [15:0] dout;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b1, 1'b1, 11'h010, 1'b0, 3'd2, 2'b01, 11'h010, 1'b1, 1'b1, 1'b0, 16'hC3A5},
        '{2'd0, 1'b0, 1'b1, 1'b1, 11'h011, 1'b0, 3'd2, 2'b10, 11'h010, 1'b1, 1'b1, 1'b0, 16'hC3C3},
        '{2'd0, 1'b1, 1'b0, 1'b0, 11'h021, 1'b0, 3'd1, 2'b10, 11'h020, 1'b1, 1'b1, 1'b0, 16'hC3A5},
        '{2'd0, 1'b0, 1'b0, 1'b0, 11'h020, 1'b0, 3'd1, 2'b11, 11'h020, 1'b1, 1'b1, 1'b0, 16'hC3A5},
        '{2'd0, 1'b1, 1'b1, 1'b1, 11'h010, 1'b0, 3'd0, 2'b00, 11'h000, 1'b0, 1'b1, 1'b0, 16'h0000},
        '{2'd0, 1'b0, 1'b1, 1'b0, 11'h010, 1'b1, 3'd0, 2'b00, 11'h000, 1'b0, 1'b1, 1'b0, 16'h0000},
        '{2'd1, 1'b0, 1'b0, 1'b0, 11'h1F0, 1'b1, 3'd3, 2'b11, 11'h1F0, 1'b1, 1'b0, 1'b0, 16'hC3A5},
        '{2'd1, 1'b0, 1'b1, 1'b0, 11'h1F7, 1'b1, 3'd3, 2'b10, 11'h1F6, 1'b1, 1'b0, 1'b1, 16'hC3C3},
        '{2'd1, 1'b0, 1'b1, 1'b0, 11'h201, 1'b0, 3'd1, 2'b10, 11'h200, 1'b1, 1'b1, 1'b1, 16'hC3C3},
        '{2'd1, 1'b0, 1'b1, 1'b1, 11'h1F0, 1'b1, 3'd0, 2'b00, 11'h000, 1'b0, 1'b1, 1'b1, 16'h0000},
        '{2'd2, 1'b0, 1'b1, 1'b0, 11'h7F8, 1'b1, 3'd4, 2'b11, 11'h000, 1'b1, 1'b1, 1'b0, 16'hC3A5},
        '{2'd2, 1'b0, 1'b1, 1'b1, 11'h005, 1'b1, 3'd4, 2'b01, 11'h005, 1'b1, 1'b1, 1'b1, 16'hC3A5},
        '{2'd2, 1'b1, 1'b0, 1'b1, 11'h006, 1'b1, 3'd5, 2'b01, 11'h006, 1'b1, 1'b1, 1'b1, 16'hC3A5},
        '{2'd2, 1'b0, 1'b0, 1'b1, 11'h000, 1'b1, 3'd0, 2'b00, 11'h000, 1'b0, 1'b1, 1'b1, 16'h0000},
        '{2'd2, 1'b0, 1'b1, 1'b1, 11'h000, 1'b0, 3'd0, 2'b00, 11'h000, 1'b0, 1'b1, 1'b0, 16'h0000}
    };

    // write: strobe low two cycles (data changes on the second), release, land on wr_en cycle
    task automatic wr_cycle(input logic use_io, input logic ce1n, input logic ce2n,
                            input logic regn, input logic [10:0] a,
                            input logic [15:0] d_first, input logic [15:0] d_last);
        @(negedge clk);
        host_ce1_n = ce1n; host_ce2_n = ce2n; host_reg_n = regn; host_addr = a;
        host_din = d_first;
        if (use_io) host_iowr_n = 1'b0; else host_we_n = 1'b0;
        @(negedge clk);
        host_din = d_last;
        #1 chk("R8 no pulse while strobe low", {15'd0, wr_en}, 16'd0);
        @(negedge clk);
        host_iowr_n = 1'b1; host_we_n = 1'b1;
        #1 chk("R8 no pulse at release", {15'd0, wr_en}, 16'd0);
        @(negedge clk);
        host_ce1_n = 1'b1; host_ce2_n = 1'b1; host_din = 16'hFFFF;
    endtask

    initial begin : watchdog
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] cur_md;
        // R11 reset state
        do_reset(2'd0);
        cur_md = 2'd0;
        chk("R11 wr_en", {15'd0, wr_en}, 16'd0);
        chk("R11 rd_en", {15'd0, rd_en}, 16'd0);
        chk("R11 doe", {15'd0, host_doe}, 16'd0);
        chk("R11 inpack_n", {15'd0, host_inpack_n}, 16'd1);

        // table of reads: R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].md != cur_md) begin
                do_reset(VECS[i].md);
                cur_md = VECS[i].md;
            end
            @(negedge clk);
            host_ce1_n = VECS[i].ce1n; host_ce2_n = VECS[i].ce2n;
            host_reg_n = VECS[i].regn; host_addr = VECS[i].a;
            if (VECS[i].use_io) host_iord_n = 1'b0; else host_oe_n = 1'b0;
            #1;
            chk($sformatf("R3_R4_R5 space v%0d", i), {13'd0, rd_space}, {13'd0, VECS[i].sp});
            chk($sformatf("R2 be v%0d", i), {14'd0, rd_be}, {14'd0, VECS[i].be});
            chk($sformatf("R2 addr v%0d", i), {5'd0, rd_addr}, {5'd0, VECS[i].ea});
            chk($sformatf("R7 doe v%0d", i), {15'd0, host_doe}, {15'd0, VECS[i].doe});
            chk($sformatf("R6 rd_en v%0d", i), {15'd0, rd_en}, {15'd0, VECS[i].doe});
            chk($sformatf("R7 dout v%0d", i), host_dout, VECS[i].dout);
            chk($sformatf("R9 inpack v%0d", i), {15'd0, host_inpack_n}, {15'd0, VECS[i].inp});
            chk($sformatf("R10 iois16 v%0d", i), {15'd0, host_iois16_n}, {15'd0, VECS[i].i16});
            @(negedge clk);
            host_oe_n = 1'b1; host_iord_n = 1'b1; host_ce1_n = 1'b1; host_ce2_n = 1'b1;
        end

        // R1: mode holds after release although oe_n and cfg_io move (currently IDE)
        @(negedge clk);
        host_oe_n = 1'b0; cfg_io = 1'b1;
        repeat (2) @(negedge clk);
        host_oe_n = 1'b1;
        #1 chk("R1 mode held", {14'd0, mode_o}, 16'd2);

        // R5 R8: IDE data register word write via I/O write strobe
        wr_cycle(1'b1, 1'b0, 1'b1, 1'b1, 11'h000, 16'h1111, 16'hBEEF);
        #1;
        chk("R8 ide wr_en", {15'd0, wr_en}, 16'd1);
        chk("R5 ide wr_space", {13'd0, wr_space}, 16'd4);
        chk("R5 ide wr_be", {14'd0, wr_be}, 16'd3);
        chk("R8 ide wr_data trailing", wr_data, 16'hBEEF);
        @(negedge clk);
        #1 chk("R8 single pulse", {15'd0, wr_en}, 16'd0);

        // R5: memory write strobe ignored in IDE mode
        wr_cycle(1'b0, 1'b0, 1'b1, 1'b1, 11'h003, 16'h0101, 16'h0202);
        #1 chk("R5 we ignored in ide", {15'd0, wr_en}, 16'd0);

        // R8 R2: memory mode odd byte on low lane
        do_reset(2'd0);
        wr_cycle(1'b0, 1'b0, 1'b1, 1'b1, 11'h041, 16'h1234, 16'h55AB);
        #1;
        chk("R8 mem wr_en", {15'd0, wr_en}, 16'd1);
        chk("R3 mem wr_space", {13'd0, wr_space}, 16'd2);
        chk("R2 mem wr_addr", {5'd0, wr_addr}, 16'h0040);
        chk("R2 mem wr_be", {14'd0, wr_be}, 16'd2);
        chk("R8 odd low lane data", {8'd0, wr_data[15:8]}, 16'h00AB);

        // R6: write strobe with both enables high
        wr_cycle(1'b0, 1'b1, 1'b1, 1'b1, 11'h041, 16'h1234, 16'h5678);
        #1 chk("R6 idle write", {15'd0, wr_en}, 16'd0);

        // R4 R8: I/O mode, high-lane odd byte via I/O write
        do_reset(2'd1);
        wr_cycle(1'b1, 1'b1, 1'b0, 1'b0, 11'h1F3, 16'h0000, 16'h9A77);
        #1;
        chk("R8 io wr_en", {15'd0, wr_en}, 16'd1);
        chk("R4 io wr_space", {13'd0, wr_space}, 16'd3);
        chk("R2 io wr_be", {14'd0, wr_be}, 16'd2);
        chk("R8 io high lane data", {8'd0, wr_data[15:8]}, 16'h009A);

        // R4: I/O write with reg_n high ignored
        wr_cycle(1'b1, 1'b0, 1'b0, 1'b1, 11'h1F0, 16'h0000, 16'h1234);
        #1 chk("R4 reg_n high ignored", {15'd0, wr_en}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule